// File: doc/BRIEF.md
# Selectable Serial Test-Pattern Source

This block is a serial test-pattern source. It sends one bit on each enabled clock. It can produce one of three streams:

- a 7-stage pseudo-random binary sequence;
- a 31-stage pseudo-random binary sequence;
- a 64-bit word, programmed by the user, that repeats without end.

A true/complement control can flip the two pseudo-random streams. This control has no effect on the user word.

The block is meant to sit in front of a serializer or a link-test path. Configuration logic elsewhere drives the select and the user word as plain levels. The generator notices by itself when the select value or the user word changes. It then restarts the chosen source from its defined starting point, so the pattern seen downstream always begins at a known place.

With every control input at zero, the block produces the complemented 31-stage sequence. That is its default stream.

Top module: `pattern_source`

## Requirements
- R1: The 2-bit `patSel` picks the source: 2'b01 selects PRBS7, 2'b10 selects the user word, and both 2'b00 and 2'b11 select PRBS31.
- R2: While `rst` is high at a rising edge, `dataOut` becomes 0, both shift registers load all ones and the user-word index loads 63. With `patSel` = 0, `keepTrue` = 0 and `enable` = 1 after reset, the stream is the complemented PRBS31.
- R3: In PRBS7 mode, each enabled edge computes new = s[6] XOR s[5] from the 7-bit state s. The state shifts left with the new bit entering at bit 0. `dataOut` takes the new bit, complemented when the complement is active, at that same edge. The sequence repeats every 127 bits.
- R4: In PRBS31 mode, each enabled edge computes new = s[30] XOR s[27] from the 31-bit state s. The shift and the output behave as in R3. Starting from the all-ones seed, the first 28 bits before complement are 0.
- R5: In either PRBS mode, `keepTrue` = 0 complements the output and `keepTrue` = 1 leaves it true. A change of `keepTrue` affects the next output bit and does not restart the sequence.
- R6: In user mode, each enabled edge puts `userWord[idx]` on `dataOut`, starting at idx 63 and counting down. After bit 0 the index wraps back to 63, so the stream repeats every 64 bits.
- R7: In user mode, `keepTrue` has no effect on `dataOut`.
- R8: While `enable` is low, `dataOut` and all generator state hold.
- R9: At any edge where `patSel` or `userWord` differs from its value at the previous edge, the seeds and the index reload and `dataOut` holds, whatever `enable` is. The next enabled edge emits the first bit of the new stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advance the stream by one bit per clock |
| patSel | input | 2 | Source select (see R1) |
| keepTrue | input | 1 | 1 leaves PRBS output true; 0 complements it |
| userWord | input | 64 | Programmed word, sent MSB first |
| dataOut | output | 1 | Registered serial output bit |

## Verification
The PRBS7 stream runs over two full periods, in true form and in complement. This separates a wrong tap from a wrong shift direction, and the period check catches a stall or a short cycle. PRBS31 runs from its seed both at the default setting and at the alternate select code. Its long initial run of zeros shows whether the seed and the tap positions are right.

Three user words are used:
- a word with only the end bits set, which exposes bit-order and wrap errors;
- a dense irregular word;
- an ascending-nibble word, which is swapped in mid-stream to prove that a change restarts at the MSB.

Toggling the complement control, pausing `enable`, and changing the configuration while `enable` is low each test a separate rule for holding or restarting.

// File: rtl/pattern_source_pkg.sv
package pattern_source_pkg;

  typedef enum logic [1:0] {
    MODE_PRBS31 = 2'd0,
    MODE_PRBS7  = 2'd1,
    MODE_USER   = 2'd2
  } srcMode_e;

  typedef struct packed {
    logic     restart;
    logic     advance;
    srcMode_e mode;
    logic     invert;
  } ctrlStrobe_t;

endpackage

// File: rtl/pattern_lfsr.sv
module pattern_lfsr #(
  parameter int WIDTH  = 7,
  parameter int TAP_HI = 6,
  parameter int TAP_LO = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic reload,
  input  logic step,
  output logic nextBit
);

  logic [WIDTH-1:0] state;

  assign nextBit = state[TAP_HI] ^ state[TAP_LO];

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      state <= '1;
    end else if (step) begin
      state <= {state[WIDTH-2:0], nextBit};
    end
  end

endmodule

// File: rtl/pattern_ctrl.sv
module pattern_ctrl
  import pattern_source_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [1:0]        patSel,
  input  logic              keepTrue,
  input  logic [WORD_W-1:0] userWord,
  output ctrlStrobe_t       strobe
);

  logic [1:0]        lastSel;
  logic [WORD_W-1:0] lastWord;
  logic              changeSeen;
  srcMode_e          modeNow;

  always_ff @(posedge clk) begin
    lastSel  <= patSel;
    lastWord <= userWord;
  end

  assign changeSeen = (patSel != lastSel) || (userWord != lastWord);

  always_comb begin
    case (patSel)
      2'b01:   modeNow = MODE_PRBS7;
      2'b10:   modeNow = MODE_USER;
      default: modeNow = MODE_PRBS31;
    endcase
  end

  always_comb begin
    strobe.restart = changeSeen && !rst;
    strobe.advance = enable && !changeSeen && !rst;
    strobe.mode    = modeNow;
    strobe.invert  = !keepTrue && (modeNow != MODE_USER);
  end

endmodule

// File: rtl/pattern_datapath.sv
module pattern_datapath
  import pattern_source_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] userWord,
  output logic              dataOut
);

  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(WORD_W - 1);

  logic             p7Bit;
  logic             p31Bit;
  logic [IDX_W-1:0] idx;
  logic             rawBit;
  logic             outBit;

  pattern_lfsr #(.WIDTH(7), .TAP_HI(6), .TAP_LO(5)) u_lfsr7 (
    .clk    (clk),
    .rst    (rst),
    .reload (strobe.restart),
    .step   (strobe.advance && (strobe.mode == MODE_PRBS7)),
    .nextBit(p7Bit)
  );

  pattern_lfsr #(.WIDTH(31), .TAP_HI(30), .TAP_LO(27)) u_lfsr31 (
    .clk    (clk),
    .rst    (rst),
    .reload (strobe.restart),
    .step   (strobe.advance && (strobe.mode == MODE_PRBS31)),
    .nextBit(p31Bit)
  );

  always_ff @(posedge clk) begin
    if (rst || strobe.restart) begin
      idx <= IDX_TOP;
    end else if (strobe.advance && (strobe.mode == MODE_USER)) begin
      idx <= (idx == '0) ? IDX_TOP : idx - 1'b1;
    end
  end

  always_comb begin
    case (strobe.mode)
      MODE_PRBS7: rawBit = p7Bit;
      MODE_USER:  rawBit = userWord[idx];
      default:    rawBit = p31Bit;
    endcase
    outBit = rawBit ^ strobe.invert;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut <= 1'b0;
    end else if (strobe.advance) begin
      dataOut <= outBit;
    end
  end

endmodule

// File: rtl/pattern_source.sv
module pattern_source
  import pattern_source_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [1:0]        patSel,
  input  logic              keepTrue,
  input  logic [WORD_W-1:0] userWord,
  output logic              dataOut
);

  ctrlStrobe_t strobe;

  pattern_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .patSel  (patSel),
    .keepTrue(keepTrue),
    .userWord(userWord),
    .strobe  (strobe)
  );

  pattern_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .userWord(userWord),
    .dataOut (dataOut)
  );

endmodule

// File: rtl/pattern_source_chk.sv
module pattern_source_chk #(
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [1:0]        patSel,
  input logic              keepTrue,
  input logic [WORD_W-1:0] userWord,
  input logic              dataOut
);

  // R2
  reset_clears_out_chk: assert property (@(posedge clk)
    rst |=> !dataOut);

  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable && !$past(rst)) |=> $stable(dataOut));

  // R9
  restart_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (patSel != $past(patSel) || userWord != $past(userWord)))
      |=> $stable(dataOut));

  // R6
  user_msb_first_chk: assert property (@(posedge clk) disable iff (rst)
    ((!$past(rst) && patSel != $past(patSel) && patSel == 2'b10)
      ##1 (enable && patSel == $past(patSel) && userWord == $past(userWord)))
      |=> dataOut == $past(userWord[WORD_W-1]));

  // R5
  prbs_first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    ((!$past(rst) && patSel != $past(patSel) && patSel != 2'b10)
      ##1 (enable && patSel == $past(patSel) && userWord == $past(userWord)))
      |=> dataOut == !$past(keepTrue));

endmodule

bind pattern_source pattern_source_chk #(.WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .enable  (enable),
  .patSel  (patSel),
  .keepTrue(keepTrue),
  .userWord(userWord),
  .dataOut (dataOut)
);

// File: tb/pattern_source_bench.sv
`timescale 1ns/1ps
module pattern_source_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        enable;
  logic [1:0]  patSel;
  logic        keepTrue;
  logic [63:0] userWord;
  logic        dataOut;

  int   vectors = 0;
  int   misses  = 0;
  bit   done    = 0;

  logic [6:0]  m7;
  logic [30:0] m31;
  int          mIdx;
  logic        lastOut;
  logic        hist [0:511];
  int          histLen;

  always #2 clk = ~clk;

  pattern_source u_pattern_source (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .patSel  (patSel),
    .keepTrue(keepTrue),
    .userWord(userWord),
    .dataOut (dataOut)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  task automatic check(logic got, logic want, string req);
    vectors++;
    if (got !== want) begin
      misses++;
      $display("FAIL %s: dataOut=%0b expected %0b at %0t", req, got, want, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic reseed();
    m7      = '1;
    m31     = '1;
    mIdx    = 63;
    histLen = 0;
  endtask

  task automatic runBits(int n, string req);
    for (int i = 0; i < n; i++) begin
      logic want;
      logic fb;
      if (!enable) begin
        want = lastOut;
      end else begin
        case (patSel)
          2'b01: begin
            fb   = m7[6] ^ m7[5];
            m7   = {m7[5:0], fb};
            want = fb ^ ~keepTrue;
          end
          2'b10: begin
            want = userWord[mIdx];
            mIdx = (mIdx == 0) ? 63 : mIdx - 1;
          end
          default: begin
            fb   = m31[30] ^ m31[27];
            m31  = {m31[29:0], fb};
            want = fb ^ ~keepTrue;
          end
        endcase
      end
      tick();
      check(dataOut, want, req);
      if (histLen < 512) begin
        hist[histLen] = dataOut;
        histLen++;
      end
      lastOut = want;
    end
  endtask

  // R9: a change restarts the source and holds the output for one edge
  task automatic setConfig(logic [1:0] sel, logic [63:0] word);
    patSel   = sel;
    userWord = word;
    tick();
    check(dataOut, lastOut, "R9");
    reseed();
  endtask

  initial begin
    #(200000 * 4);
    misses++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    summary();
  end

  initial begin
    rst      = 1'b1;
    enable   = 1'b1;
    patSel   = 2'b00;
    keepTrue = 1'b0;
    userWord = 64'h0;
    lastOut  = 1'b0;
    reseed();
    tick(); tick(); tick();
    check(dataOut, 1'b0, "R2");
    rst = 1'b0;

    // R2 / R4: default stream is complemented PRBS31; first 28 raw bits are 0
    runBits(28, "R4");
    for (int i = 0; i < 28; i++) check(hist[i], 1'b1, "R4");
    runBits(172, "R2");

    // R5: switch to true form without restart
    keepTrue = 1'b1;
    runBits(100, "R5");

    // R3: PRBS7, two full periods, periodicity 127
    setConfig(2'b01, 64'h0);
    runBits(254, "R3");
    for (int i = 0; i < 127; i++) check(hist[i + 127], hist[i], "R3");

    // R5: complement PRBS7 mid-stream
    keepTrue = 1'b0;
    runBits(60, "R5");

    // R8: pause then resume
    enable = 1'b0;
    runBits(10, "R8");
    enable = 1'b1;
    runBits(20, "R8");

    // R6 / R7: user words, complement toggled, wrap exercised
    setConfig(2'b10, 64'h8000_0000_0000_0001);
    keepTrue = 1'b0;
    runBits(64, "R6");
    keepTrue = 1'b1;
    runBits(70, "R7");
    for (int i = 0; i < 64; i++) check(hist[i + 64], hist[i], "R6");

    setConfig(2'b10, 64'hA5C3_0F96_1E2D_3C4B);
    keepTrue = 1'b0;
    runBits(40, "R7");

    // R9: word swap mid-stream restarts at the MSB
    setConfig(2'b10, 64'h0123_4567_89AB_CDEF);
    runBits(130, "R6");

    // R1: alternate PRBS31 code, then PRBS31 code proper
    setConfig(2'b11, 64'h0123_4567_89AB_CDEF);
    runBits(100, "R1");
    keepTrue = 1'b1;
    setConfig(2'b00, 64'h0123_4567_89AB_CDEF);
    runBits(60, "R1");

    // R9: change while disabled, output holds, restart still taken
    enable = 1'b0;
    setConfig(2'b01, 64'h0);
    runBits(5, "R9");
    enable = 1'b1;
    runBits(40, "R9");

    summary();
  end

endmodule